// File: doc/BRIEF.md
# Priority-Chained Single-Cycle Mutex Bank

This block holds a bank of one-bit locks shared by a fixed set of requesters. The requesters have a strict rank: index 0 is the most senior and the last index is the most junior. In any clock cycle each requester may ask to take any lock in the bank, and may also ask to release any lock. The answer to a take request comes back in that same cycle through a grant vector. Take requests that lose, or that target a lock already held, return 0.

Arbitration runs as a one-way combinational chain. Each stage tells the stages below it which locks are already taken, and nothing flows back up, so no combinational loop can form. Lock state lives in a register. A release is applied at the next clock edge, so the lock is free again from the following cycle on. A requester that takes and releases a lock in one cycle therefore holds it for exactly that cycle.

Top module: `prio_mutex_bank`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) leaves every lock free, so the first take request after reset is granted even from the most junior requester.
- R2: A take request on a lock that is free at the start of the cycle, with no more senior taker of that lock, sets the matching grant bit in the same cycle, with no clock edge in between.
- R3: When several requesters ask for the same free lock in one cycle, only the one with the lowest index is granted. The bit for requester r and lock m is at position r*NUM_MTX+m in `lock_req`, `unlock_req` and `grant`.
- R4: Once a lock has been granted and no release was asked for it in that cycle, every take request on it in later cycles fails until a release is made.
- R5: A release frees the lock from the next cycle on. Take requests made in the same cycle as the release still fail, and a take request in the next cycle is granted. Any requester may release any lock.
- R6: A requester that takes and releases a free lock in one cycle gets the grant, more junior takers of that lock fail in that cycle, and the lock is free in the next cycle.
- R7: A lock held at the start of a cycle refuses every take request in that cycle. Those refused requests have no effect on grants for any other lock.
- R8: A release request for a lock that is free, with no grant on it in the same cycle, is ignored: the lock stays free and a later take request on it is granted.
- R9: A grant bit is never set without the matching take request. One requester may take several locks in one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; lock state updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lock_req | input | NUM_REQ*NUM_MTX | Take requests, requester r owns slice [r*NUM_MTX +: NUM_MTX] |
| unlock_req | input | NUM_REQ*NUM_MTX | Release requests, same packing |
| grant | output | NUM_REQ*NUM_MTX | Same-cycle take results, same packing |

## Verification
Two functions can meet on the same lock in one cycle: a take and a release. The first case is a release of a held lock paired with another requester's take, where the take must fail and a take one cycle later must win. The second case is a single requester taking and releasing a free lock while a more junior requester also asks for it: the senior one wins, the junior one fails, and the lock is free one cycle later. The bench drives each case in a directed task and checks the grant in the cycle of the collision and again in the next cycle.

// File: rtl/mtx_pkg.sv
// Package: shared helpers for the mutex bank.
// Assumes requester-major packing of all flat request and grant vectors.
package mtx_pkg;

    // Flat bit index for requester r, lock m, in a bank of nm locks.
    function automatic int unsigned flat_idx(input int unsigned r,
                                             input int unsigned m,
                                             input int unsigned nm);
        return r * nm + m;
    endfunction

endpackage

// File: rtl/mtx_chain_stage.sv
// Module: one link of the priority chain, serving one requester.
// Takes the set of locks already claimed by more senior links (or held at
// the start of the cycle) and grants only the requested locks not in it.
// Assumes taken_in depends only on more senior links, so no loop forms.
module mtx_chain_stage #(
    parameter int NUM_MTX = 8
) (
    input  logic [NUM_MTX-1:0] taken_in,
    input  logic [NUM_MTX-1:0] want,
    output logic [NUM_MTX-1:0] won,
    output logic [NUM_MTX-1:0] taken_out
);

    // Grant free locks and mark every requested lock taken for junior links.
    always_comb begin
        won       = want & ~taken_in;
        taken_out = taken_in | want;
    end

endmodule

// File: rtl/mtx_state_reg.sv
// Module: per-lock state register.
// A lock becomes held when it was held or claimed this cycle, and becomes
// free when any release was requested for it this cycle (release wins).
// Assumes a synchronous active-low reset.
module mtx_state_reg #(
    parameter int NUM_MTX = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MTX-1:0] claimed,
    input  logic [NUM_MTX-1:0] released,
    output logic [NUM_MTX-1:0] held_q
);

    logic [NUM_MTX-1:0] held_d;

    // Compute next state: release overrides a same-cycle claim.
    always_comb begin
        held_d = (held_q | claimed) & ~released;
    end

    // Register lock state, clearing all locks on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_d;
    end

endmodule

// File: rtl/prio_mutex_bank.sv
// Module: bank of NUM_MTX one-bit locks shared by NUM_REQ ranked requesters.
// Requester 0 is the most senior. Grants are combinational in the request
// cycle; releases take effect at the next clock edge.
// Assumes requester-major packing: bit r*NUM_MTX+m is requester r, lock m.
module prio_mutex_bank #(
    parameter int NUM_REQ = 4,
    parameter int NUM_MTX = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_REQ*NUM_MTX-1:0] lock_req,
    input  logic [NUM_REQ*NUM_MTX-1:0] unlock_req,
    output logic [NUM_REQ*NUM_MTX-1:0] grant
);
    import mtx_pkg::*;

    localparam int FLAT_W = NUM_REQ * NUM_MTX;

    logic [NUM_MTX-1:0] taken_chain   [NUM_REQ+1];
    logic [NUM_MTX-1:0] release_chain [NUM_REQ+1];
    logic [NUM_MTX-1:0] state_q;

    // Chain heads: locks held at cycle start, no releases yet.
    always_comb begin
        taken_chain[0]   = state_q;
        release_chain[0] = '0;
    end

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
        localparam int unsigned BASE = flat_idx(r, 0, NUM_MTX);

        mtx_chain_stage #(.NUM_MTX(NUM_MTX)) u_stage (
            .taken_in  (taken_chain[r]),
            .want      (lock_req[BASE +: NUM_MTX]),
            .won       (grant[BASE +: NUM_MTX]),
            .taken_out (taken_chain[r+1])
        );

        // Accumulate release requests from every requester.
        always_comb begin
            release_chain[r+1] = release_chain[r] | unlock_req[BASE +: NUM_MTX];
        end
    end

    mtx_state_reg #(.NUM_MTX(NUM_MTX)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .claimed  (taken_chain[NUM_REQ]),
        .released (release_chain[NUM_REQ]),
        .held_q   (state_q)
    );

    // Elaboration check that the flat width stays consistent.
    initial begin
        if ($bits(grant) != FLAT_W) $display("prio_mutex_bank: width mismatch");
    end

endmodule

// File: rtl/mtx_bank_checker.sv
// Module: property checker for prio_mutex_bank, attached by bind.
// Assumes the same packing and ranking as the checked block.
module mtx_bank_checker #(
    parameter int NUM_REQ = 4,
    parameter int NUM_MTX = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_REQ*NUM_MTX-1:0] lock_req,
    input logic [NUM_REQ*NUM_MTX-1:0] unlock_req,
    input logic [NUM_REQ*NUM_MTX-1:0] grant,
    input logic [NUM_MTX-1:0]         state_q
);

    // R1: reset leaves every lock free.
    assert_reset_free_R1: assert property (@(posedge clk)
        !rst_n |=> (state_q == '0));

    for (genvar m = 0; m < NUM_MTX; m++) begin : g_mtx
        logic [NUM_REQ-1:0] col_grant, col_lock, col_unlock;
        logic [NUM_REQ-1:0] senior_req;

        // Gather one lock's column and the OR of more senior take requests.
        always_comb begin
            senior_req[0] = 1'b0;
            for (int r = 0; r < NUM_REQ; r++) begin
                col_grant[r]  = grant[r*NUM_MTX+m];
                col_lock[r]   = lock_req[r*NUM_MTX+m];
                col_unlock[r] = unlock_req[r*NUM_MTX+m];
                if (r > 0) senior_req[r] = senior_req[r-1] | col_lock[r-1];
            end
        end

        // R2: senior-most take of a free lock is granted at once.
        assert_free_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (col_lock[0] && !state_q[m]) |-> col_grant[0]);

        // R3: at most one winner per lock per cycle.
        assert_single_winner_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col_grant));

        // R4: a granted lock not released refuses takes next cycle.
        assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ((|col_grant) && !(|col_unlock)) |=> (col_grant == '0));

        // R5: a release leaves the lock free in the next cycle.
        assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (|col_unlock) |=> !state_q[m]);

        // R7: a lock held at cycle start grants nothing.
        assert_held_refuses_R7: assert property (@(posedge clk) disable iff (!rst_n)
            state_q[m] |-> (col_grant == '0));

        for (genvar r = 0; r < NUM_REQ; r++) begin : g_r
            // R3: no grant while a more senior requester asks for the lock.
            assert_senior_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
                col_grant[r] |-> !senior_req[r]);

            // R9: grant only with a matching take request.
            assert_grant_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
                col_grant[r] |-> col_lock[r]);
        end
    end

endmodule

bind prio_mutex_bank mtx_bank_checker #(
    .NUM_REQ (NUM_REQ),
    .NUM_MTX (NUM_MTX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_req   (lock_req),
    .unlock_req (unlock_req),
    .grant      (grant),
    .state_q    (state_q)
);

// File: tb/test_prio_mutex_bank.sv
// Bench: directed tests for prio_mutex_bank, one task per scenario.
module test_prio_mutex_bank;

    localparam int NR = 4;
    localparam int NM = 8;
    localparam int W  = NR * NM;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] lk = '0;
    logic [W-1:0] ul = '0;
    logic [W-1:0] gnt;
    int checks = 0;
    int fails  = 0;

    prio_mutex_bank #(.NUM_REQ(NR), .NUM_MTX(NM)) i_prio_mutex_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_req   (lk),
        .unlock_req (ul),
        .grant      (gnt)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    function automatic logic [W-1:0] b(input int r, input int m);
        return {{(W-1){1'b0}}, 1'b1} << (r*NM + m);
    endfunction

    // Drive one cycle of requests at the falling edge and check the grant.
    task automatic cyc(input logic [W-1:0] l, input logic [W-1:0] u,
                       input logic [W-1:0] exp, input string tag);
        @(negedge clk);
        lk = l;
        ul = u;
        #5;
        checks++;
        if (gnt !== exp) begin
            fails++;
            $display("FAIL %s: grant=%h expected=%h", tag, gnt, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        lk = '0;
        ul = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        cyc('0, '0, '0, "R1 idle after reset");
        cyc(b(3,0), '0, b(3,0), "R1 junior take after reset");
    endtask

    task automatic t_basic();
        do_reset();
        cyc(b(0,1) | b(2,5), '0, b(0,1) | b(2,5), "R2 same-cycle grants");
    endtask

    task automatic t_priority();
        do_reset();
        cyc(b(1,2) | b(2,2) | b(3,2), '0, b(1,2), "R3 senior wins");
        cyc(b(0,2), '0, '0, "R4 most senior refused on held lock");
    endtask

    task automatic t_hold();
        do_reset();
        cyc(b(0,3), '0, b(0,3), "R4 first take");
        cyc(b(0,3) | b(1,3), '0, '0, "R4 held cycle 2");
        cyc(b(2,3), '0, '0, "R4 held cycle 3");
    endtask

    task automatic t_release();
        do_reset();
        cyc(b(2,4), '0, b(2,4), "R5 take");
        cyc(b(0,4), b(2,4), '0, "R5 take during release fails");
        cyc(b(3,4), '0, b(3,4), "R5 free next cycle");
    endtask

    task automatic t_same_cycle();
        do_reset();
        cyc(b(1,6) | b(2,6), b(1,6), b(1,6), "R6 take+release wins cycle");
        cyc(b(2,6), '0, b(2,6), "R6 free next cycle");
    endtask

    task automatic t_locked_indep();
        do_reset();
        cyc(b(0,7), '0, b(0,7), "R7 setup take");
        cyc(b(0,7) | b(1,7) | b(2,0), '0, b(2,0), "R7 held refuses, other lock granted");
    endtask

    task automatic t_ignore_unlock();
        do_reset();
        cyc('0, b(3,5), '0, "R8 release of free lock");
        cyc(b(1,5), '0, b(1,5), "R8 lock still free");
        cyc(b(2,5), '0, '0, "R8 lock now held");
    endtask

    task automatic t_mask();
        do_reset();
        cyc('0, '0, '0, "R9 no request no grant");
        cyc({{(W-NM){1'b0}}, {NM{1'b1}}}, '0, {{(W-NM){1'b0}}, {NM{1'b1}}},
            "R9 one requester takes all");
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_priority();
        t_hold();
        t_release();
        t_same_cycle();
        t_locked_indep();
        t_ignore_unlock();
        t_mask();
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule